// File: doc/BRIEF.md
# Knob Digitiser by Ramp Threshold Crossing

This block turns the position of hand-turned knobs into 8-bit numbers without an analog-to-digital converter. A shared time base walks a level counter upward from 0 to 255 and then wraps. At every level it emits a pulse-width-modulated bit whose duty cycle follows that level. An external resistor and capacitor network filters this bit, adds it to the knob wiper voltage and returns the sum to the chip as a plain logic input. As the ramp rises, that input crosses the logic threshold at a level that depends on the knob angle.

One capture channel is built per knob. Each channel passes its threshold input through a synchroniser and watches for the first low-to-high transition in the sweep. It latches the ramp level seen at that moment. When the sweep ends, the channel publishes the latched level as its reading and pulses a valid flag for one cycle. Every channel shares the single time base.

The dwell at each level is set by parameters, as a number of PWM frames per level, so the filter can settle before the next step. With `FRAME_BITS = 8` and `HOLD_FRAMES = 95` at a 50 MHz clock, one sweep lasts about 125 ms, which gives roughly eight readings per second.

Top module: `knob_digitizer`

## Requirements
- R1: The ramp level on `ramp_level_o` starts at 0 after reset and rises by exactly 1 at each step, wrapping from 255 to 0. Each level is held for 2^FRAME_BITS × HOLD_FRAMES clock cycles.
- R2: `sweep_start_o` is a one-cycle pulse that is high only in the first cycle of level 0 following level 255. No pulse is produced in the cycles right after reset.
- R3: Within each PWM frame of 2^FRAME_BITS cycles, `pwm_o` is high for D cycles and low for the rest. D is the value of the top FRAME_BITS bits of the ramp level. The output lags the frame position by one register, and it stays low whenever D is 0.
- R4: Each threshold input passes through a two-flop synchroniser before edge detection. When an input rises in the first cycle of a level and each level lasts at least 4 cycles, the reading for that sweep equals that level.
- R5: If no rising edge is seen during a sweep and the synchronised input is low at the sweep's end, the reading is 255.
- R6: If no rising edge is seen during a sweep and the synchronised input is high at the sweep's end (already above threshold), the reading is 0.
- R7: The readings and valid flags change only at a sweep boundary. `valid_o[c]` is high for exactly the one cycle after `sweep_start_o`, and in that cycle channel c's reading holds the result of the sweep that just ended. The first sweep after reset produces no reading.
- R8: Channels are independent. Channel c reads bits [8c+7:8c] of `reading_o` and uses input `thr_i[c]`, and each channel gives its own result from the same sweep.
- R9: A rising edge seen in the cycle `sweep_start_o` is high belongs to the sweep that is ending and gives it the reading 255. The new sweep starts with no edge recorded.
- R10: While reset is applied and after it is released, `pwm_o`, `sweep_start_o` and `valid_o` are low, and `ramp_level_o` and `reading_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thr_i | input | CHANNELS | Asynchronous threshold input per knob |
| pwm_o | output | 1 | Ramp-modulated pulse train to the external filter |
| sweep_start_o | output | 1 | One-cycle strobe at the start of each sweep |
| ramp_level_o | output | 8 | Current ramp level shared with the capture channels |
| reading_o | output | 8*CHANNELS | Held reading per channel, channel c in bits [8c+7:8c] |
| valid_o | output | CHANNELS | One-cycle update marker per channel |

## Verification
The risky coincidence is a threshold crossing that reaches the edge detector in the same cycle that the sweep-start strobe closes the sweep. Both the closing of the old sweep and the recording of a crossing then compete for the same channel state. The bench provokes this by holding one channel's input low for a whole sweep. It then raises the input at the falling clock edge two cycles into level 255, so the synchronised edge arrives exactly on the strobe cycle. It expects the closing reading to be 255 rather than the "already high" value 0. With the input kept high, the following sweep must read 0, which shows that the edge did not carry over into the new sweep.

// File: rtl/knob_pkg.sv
package knob_pkg;
  localparam int RAMP_W   = 8;
  localparam int RAMP_MAX = (1 << RAMP_W) - 1;
  typedef logic [RAMP_W-1:0] level_t;
endpackage

// File: rtl/knob_sync2.sv
module knob_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/knob_ramp_gen.sv
module knob_ramp_gen
  import knob_pkg::*;
#(
  parameter int FRAME_BITS  = 8,
  parameter int HOLD_FRAMES = 95
) (
  input  logic   clk,
  input  logic   rst,
  output level_t level_o,
  output logic   start_o,
  output logic   pwm_o
);
  localparam int HOLD_W = (HOLD_FRAMES > 1) ? $clog2(HOLD_FRAMES) : 1;

  logic [FRAME_BITS-1:0] frm_q;
  logic [HOLD_W-1:0]     hold_q;
  level_t                lvl_q;
  logic                  start_q;
  logic                  pwm_q;

  logic                  frame_last;
  logic                  hold_last;
  logic                  step;
  logic [FRAME_BITS-1:0] duty;

  assign frame_last = &frm_q;
  assign hold_last  = (hold_q == HOLD_W'(HOLD_FRAMES - 1));
  assign step       = frame_last && hold_last;
  assign duty       = lvl_q[RAMP_W-1 -: FRAME_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_q   <= '0;
      hold_q  <= '0;
      lvl_q   <= '0;
      start_q <= 1'b0;
      pwm_q   <= 1'b0;
    end else begin
      frm_q <= frm_q + 1'b1;
      if (frame_last) hold_q <= hold_last ? '0 : hold_q + 1'b1;
      if (step) lvl_q <= lvl_q + 1'b1;
      start_q <= step && (lvl_q == level_t'(RAMP_MAX));
      pwm_q   <= (frm_q < duty);
    end
  end

  assign level_o = lvl_q;
  assign start_o = start_q;
  assign pwm_o   = pwm_q;

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(lvl_q) |-> (lvl_q == level_t'($past(lvl_q) + 1'b1))); // R1
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    start_q |-> (lvl_q == '0)); // R2
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q); // R2
  AST_PWM_ZERO_DUTY: assert property (@(posedge clk) disable iff (rst)
    (duty == '0) && $stable(lvl_q) |-> !pwm_q); // R3
endmodule

// File: rtl/knob_capture.sv
module knob_capture
  import knob_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_i,
  input  level_t level_i,
  input  logic   thr_i,
  output level_t reading_o,
  output logic   valid_o
);
  logic   thr_s;
  logic   prev_q;
  logic   found_q;
  logic   armed_q;
  level_t cap_q;
  level_t reading_q;
  logic   valid_q;
  logic   rise;
  level_t close_val;

  knob_sync2 #(.STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (thr_i),
    .q_o (thr_s)
  );

  assign rise = thr_s && !prev_q;

  always_comb begin
    if (found_q)    close_val = cap_q;
    else if (rise)  close_val = level_t'(RAMP_MAX);
    else if (thr_s) close_val = '0;
    else            close_val = level_t'(RAMP_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= 1'b0;
      found_q   <= 1'b0;
      armed_q   <= 1'b0;
      cap_q     <= '0;
      reading_q <= '0;
      valid_q   <= 1'b0;
    end else begin
      prev_q  <= thr_s;
      valid_q <= 1'b0;
      if (start_i) begin
        if (armed_q) begin
          reading_q <= close_val;
          valid_q   <= 1'b1;
        end
        armed_q <= 1'b1;
        found_q <= 1'b0;
      end else if (rise && !found_q) begin
        found_q <= 1'b1;
        cap_q   <= level_i;
      end
    end
  end

  assign reading_o = reading_q;
  assign valid_o   = valid_q;

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> $past(start_i)); // R7
  AST_READING_HELD: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> $stable(reading_q)); // R7
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q); // R7
  AST_FRESH_SWEEP: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !found_q); // R9
endmodule

// File: rtl/knob_digitizer.sv
module knob_digitizer
  import knob_pkg::*;
#(
  parameter int CHANNELS    = 2,
  parameter int FRAME_BITS  = 8,
  parameter int HOLD_FRAMES = 95
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CHANNELS-1:0]          thr_i,
  output logic                         pwm_o,
  output logic                         sweep_start_o,
  output logic [RAMP_W-1:0]            ramp_level_o,
  output logic [CHANNELS*RAMP_W-1:0]   reading_o,
  output logic [CHANNELS-1:0]          valid_o
);
  level_t level;
  logic   start;

  knob_ramp_gen #(
    .FRAME_BITS  (FRAME_BITS),
    .HOLD_FRAMES (HOLD_FRAMES)
  ) u_ramp (
    .clk     (clk),
    .rst     (rst),
    .level_o (level),
    .start_o (start),
    .pwm_o   (pwm_o)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    knob_capture u_cap (
      .clk       (clk),
      .rst       (rst),
      .start_i   (start),
      .level_i   (level),
      .thr_i     (thr_i[c]),
      .reading_o (reading_o[c*RAMP_W +: RAMP_W]),
      .valid_o   (valid_o[c])
    );
  end

  assign sweep_start_o = start;
  assign ramp_level_o  = level;
endmodule

// File: tb/knob_digitizer_tb.sv
module knob_digitizer_tb;
  localparam int CH = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CH-1:0] thr_i = '0;
  logic          pwm_o;
  logic          sweep_start_o;
  logic [7:0]    ramp_level_o;
  logic [CH*8-1:0] reading_o;
  logic [CH-1:0] valid_o;

  int tests = 0;
  int fails = 0;
  int thr_k [CH];
  logic man_en [CH];
  logic man_val [CH];

  always #10 clk = ~clk;

  knob_digitizer #(.CHANNELS(CH), .FRAME_BITS(2), .HOLD_FRAMES(1)) u_dut (
    .clk (clk), .rst (rst), .thr_i (thr_i), .pwm_o (pwm_o),
    .sweep_start_o (sweep_start_o), .ramp_level_o (ramp_level_o),
    .reading_o (reading_o), .valid_o (valid_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // knob model: input high once the ramp reaches the channel's threshold level
  initial begin
    for (int c = 0; c < CH; c++) begin thr_k[c] = 256; man_en[c] = 0; man_val[c] = 0; end
    forever begin
      @(negedge clk);
      for (int c = 0; c < CH; c++)
        thr_i[c] = man_en[c] ? man_val[c] : (int'(ramp_level_o) >= thr_k[c]);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    finish_run();
  end

  task automatic wait_start();
    do @(negedge clk); while (!sweep_start_o);
  endtask

  task automatic test_reset_r10();
    repeat (3) @(negedge clk);
    chk(pwm_o == 0 && sweep_start_o == 0 && valid_o == 0, "R10 outputs in reset", int'(pwm_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ramp_level_o == 0, "R10 level after reset", ramp_level_o, 0);
    chk(reading_o == 0 && valid_o == 0, "R10 readings after reset", int'(reading_o), 0);
  endtask

  task automatic test_ramp_r1_r2();
    int prev, run, bad, starts, start_pos;
    wait_start();
    chk(ramp_level_o == 0, "R2 level at start", ramp_level_o, 0);
    prev = 0; run = 1; bad = 0; starts = 0; start_pos = -1;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (sweep_start_o) begin starts++; start_pos = i; end
      if (int'(ramp_level_o) != prev) begin
        if (int'(ramp_level_o) != ((prev + 1) % 256) || run != 4) bad++;
        prev = ramp_level_o; run = 1;
      end else run++;
    end
    chk(bad == 0, "R1 step and dwell", bad, 0);
    chk(starts == 1 && start_pos == 1023, "R2 one start per sweep", start_pos, 1023);
  endtask

  task automatic test_pwm_r3(input int lvl);
    int highs = 0;
    int prev;
    prev = ramp_level_o;
    forever begin
      @(negedge clk);
      if (int'(ramp_level_o) == lvl && prev != lvl) break;
      prev = ramp_level_o;
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (pwm_o) highs++;
    end
    chk(highs == (lvl >> 6), "R3 pwm high cycles", highs, lvl >> 6);
  endtask

  task automatic measure(input int k0, input int k1, input string tag);
    thr_k[0] = k0; thr_k[1] = k1;
    wait_start();
    wait_start();
    @(negedge clk);
    chk(valid_o == 2'b11, "R7 valid after start", valid_o, 3);
    chk(reading_o[7:0] == 8'((k0 > 255) ? 255 : k0), {tag, " ch0"}, reading_o[7:0], (k0 > 255) ? 255 : k0);
    chk(reading_o[15:8] == 8'((k1 > 255) ? 255 : k1), {tag, " ch1"}, reading_o[15:8], (k1 > 255) ? 255 : k1);
    @(negedge clk);
    chk(valid_o == 2'b00, "R7 valid one cycle", valid_o, 0);
  endtask

  task automatic test_hold_r7();
    logic [15:0] snap;
    thr_k[0] = 10; thr_k[1] = 200;
    wait_start();
    @(negedge clk);
    snap = reading_o;
    repeat (600) @(negedge clk);
    chk(reading_o == snap && valid_o == 0, "R7 reading held mid-sweep", int'(reading_o), int'(snap));
  endtask

  task automatic test_boundary_edge_r9();
    wait_start();
    #1 man_en[0] = 1; man_val[0] = 0;
    wait_start();
    do @(negedge clk); while (ramp_level_o != 8'd255);
    @(negedge clk);
    #1 man_val[0] = 1;
    wait_start();
    @(negedge clk);
    chk(reading_o[7:0] == 8'd255, "R9 edge on start cycle", reading_o[7:0], 255);
    wait_start();
    @(negedge clk);
    chk(reading_o[7:0] == 8'd0, "R9 next sweep fresh (R6)", reading_o[7:0], 0);
    man_en[0] = 0;
  endtask

  initial begin
    test_reset_r10();
    test_ramp_r1_r2();
    test_pwm_r3(0);
    test_pwm_r3(64);
    test_pwm_r3(128);
    test_pwm_r3(192);
    measure(8'h5A, 8'h21, "R4 R8 mid levels");
    measure(256, 0, "R5 R6 saturation");
    measure(255, 1, "R4 extreme levels");
    test_hold_r7();
    test_boundary_edge_r9();
    finish_run();
  end
endmodule